// File: doc/BRIEF.md
# CRC-16/X-25 Frame Check Engine

This engine computes a byte-serial CRC-16 over the command and response frames of a small secure-element command port. It uses the reflected X-25 arrangement: the register shifts right, the feedback constant is 0x8408, the register is loaded with 0xFFFF when a frame opens, and the reported value is the bitwise inverse of the register. The CRC covers every byte of a frame that comes before its CRC field, starting at the command ID byte.

Bytes arrive with `valid_i`. `start_i` opens a frame and `last_i` closes it. The engine takes one byte per clock, and a new frame may open on the cycle right after the previous frame closed.

The engine has two modes, chosen by `check_i` on the last byte:
- **Generate mode** (`check_i` low): the engine plays out the two CRC bytes to be appended to an outgoing frame, low byte first.
- **Check mode** (`check_i` high): the engine compares the two trailing bytes of a received frame against the CRC of the bytes before them. It reports the verdict one cycle after the last byte.

Top module: `crc_x25_frame_engine`

## Requirements
- R1: While reset is asserted and right after it, `crc_o` reads 0x0000, and `done_o`, `match_o` and `tx_valid_o` are low.
- R2: Each accepted byte updates the register in one clock as crc = T[(crc ^ byte) & 0xFF] ^ (crc >> 8), with T[1] = 0x1189 and T[255] = 0x0F78. `crc_o` shows the inverted register. From the preset, the single byte 0xFE gives 0xEE89 and the single byte 0x00 gives 0xF078.
- R3: The ASCII string "123456789" sent as one frame gives `crc_o` = 0x906E.
- R4: `start_i` together with a byte loads 0xFFFF before that byte is folded in, so frames can follow each other with no idle cycle. `start_i` without `valid_i` loads 0xFFFF, so `crc_o` reads 0x0000 on the next cycle.
- R5: A cycle with `valid_i` and `start_i` both low leaves `crc_o` unchanged and raises no `done_o`, whatever `data_i` and `last_i` carry.
- R6: `done_o` is high for exactly the one cycle after a byte is accepted with `last_i` high, and is low at all other times.
- R7: In check mode, the last two bytes of the frame are the received CRC, low byte first. `match_o` rises together with `done_o` only when that received CRC equals the inverted CRC of all earlier bytes of the frame.
- R8: A check-mode frame of fewer than three bytes always gives `match_o` low. A three-byte frame whose trailer is correct gives `match_o` high.
- R9: In generate mode, on the two cycles after the last byte, `tx_valid_o` is high. `tx_byte_o` carries the low byte of the final CRC on the first of these cycles and the high byte on the second. A newer frame's completion replaces any emission still running. A check-mode frame starts no emission.
- R10: `match_o` stays low for any frame closed with `check_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | `data_i` carries a byte this cycle |
| start_i | input | 1 | Open a frame (preset the register) |
| last_i | input | 1 | This byte closes the frame |
| check_i | input | 1 | Check mode, sampled with the last byte |
| data_i | input | DATA_W | Frame byte |
| crc_o | output | CRC_W | Inverted running CRC |
| done_o | output | 1 | Frame closed on the previous cycle |
| match_o | output | 1 | Check-mode trailer matched |
| tx_valid_o | output | 1 | `tx_byte_o` holds a CRC byte to append |
| tx_byte_o | output | DATA_W | CRC byte to append, low byte first |

## Verification
The bench builds the engine with its default widths: a 16-bit CRC over 8-bit bytes. This makes the trailer two bytes long, the shortest frame that can pass a check three bytes long, and the emission two cycles long. With these values the 0x906E check string, the two table corners T[1] and T[255], and the frame-length boundary from two to three bytes can all be checked against fixed constants. Frames of up to twenty bytes, whose trailers come from a bit-serial model in the bench, exercise the trailer comparison with both intact and corrupted bytes.

// File: rtl/crc_x25_pkg.sv
`timescale 1ns/1ps
package crc_x25_pkg;
  localparam int unsigned CRC_W_DEF   = 16;
  localparam int unsigned DATA_W_DEF  = 8;
  localparam logic [15:0] POLY_DEF    = 16'h8408;
  localparam logic [15:0] PRESET_DEF  = 16'hFFFF;
  localparam logic [15:0] XOR_OUT_DEF = 16'hFFFF;
endpackage

// File: rtl/crc_x25_byte_step.sv
`timescale 1ns/1ps
// Reflected byte fold, unrolled one stage per data bit (lsb first).
module crc_x25_byte_step #(
  parameter int unsigned       CRC_W  = 16,
  parameter int unsigned       DATA_W = 8,
  parameter logic [CRC_W-1:0]  POLY   = 16'h8408
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = crc_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb           = chain[b][0] ^ data_i[b];
    assign chain[b+1]   = (chain[b] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_o = chain[DATA_W];
endmodule

// File: rtl/crc_x25_trailer_cmp.sv
`timescale 1ns/1ps
// Compares received trailer (low byte first) against inverted prior CRC.
module crc_x25_trailer_cmp #(
  parameter int unsigned      CRC_W   = 16,
  parameter int unsigned      DATA_W  = 8,
  parameter logic [CRC_W-1:0] XOR_OUT = 16'hFFFF
) (
  input  logic [CRC_W-1:0]        base_i,
  input  logic [CRC_W-DATA_W-1:0] hist_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    enough_i,
  output logic                    pass_o
);
  logic [CRC_W-1:0] rx_crc;
  logic [CRC_W-1:0] exp_crc;

  assign rx_crc  = {data_i, hist_i};
  assign exp_crc = base_i ^ XOR_OUT;
  assign pass_o  = enough_i && (rx_crc == exp_crc);
endmodule

// File: rtl/crc_x25_tx_emit.sv
`timescale 1ns/1ps
// Plays out the final CRC one byte per cycle, low byte first.
module crc_x25_tx_emit #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned NB    = CRC_W / DATA_W;
  localparam int unsigned CNT_W = $clog2(NB + 1);

  logic [CRC_W-1:0] sh_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= crc_i;
      left_q <= CNT_W'(NB);
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> DATA_W;
      left_q <= left_q - 1'b1;
    end
  end

  assign valid_o = (left_q != '0);
  assign byte_o  = sh_q[DATA_W-1:0];
endmodule

// File: rtl/crc_x25_frame_engine.sv
`timescale 1ns/1ps
module crc_x25_frame_engine
  import crc_x25_pkg::*;
#(
  parameter int unsigned      CRC_W   = CRC_W_DEF,
  parameter int unsigned      DATA_W  = DATA_W_DEF,
  parameter logic [CRC_W-1:0] POLY    = POLY_DEF,
  parameter logic [CRC_W-1:0] PRESET  = PRESET_DEF,
  parameter logic [CRC_W-1:0] XOR_OUT = XOR_OUT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              check_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o,
  output logic              match_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_byte_o
);
  localparam int unsigned NB      = CRC_W / DATA_W;
  localparam int unsigned MIN_LEN = NB + 1;
  localparam int unsigned CNT_W   = $clog2(MIN_LEN + 1);

  logic [CRC_W-1:0]        crc_q, base, folded;
  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic [CRC_W-DATA_W-1:0] hist_q;
  logic [CRC_W-1:0]        base_hist_q [NB-1];
  logic [CRC_W-1:0]        hist_shift;
  logic                    pass, done_q, match_q, close;

  assign base  = start_i ? PRESET : crc_q;
  assign close = valid_i && last_i;

  crc_x25_byte_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
    .crc_i  (base),
    .data_i (data_i),
    .crc_o  (folded)
  );

  // frame length counter, saturating at the shortest checkable frame
  always_comb begin
    if (start_i)                        cnt_n = CNT_W'(1);
    else if (cnt_q == CNT_W'(MIN_LEN))  cnt_n = cnt_q;
    else                                cnt_n = cnt_q + 1'b1;
  end

  crc_x25_trailer_cmp #(.CRC_W(CRC_W), .DATA_W(DATA_W), .XOR_OUT(XOR_OUT)) u_cmp (
    .base_i   (base_hist_q[NB-2]),
    .hist_i   (hist_q),
    .data_i   (data_i),
    .enough_i (cnt_n == CNT_W'(MIN_LEN)),
    .pass_o   (pass)
  );

  assign hist_shift = {data_i, hist_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q   <= PRESET;
      cnt_q   <= '0;
      hist_q  <= '0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      for (int i = 0; i < NB - 1; i++) base_hist_q[i] <= PRESET;
    end else begin
      done_q  <= close;
      match_q <= close && check_i && pass;
      if (valid_i) begin
        crc_q  <= folded;
        cnt_q  <= cnt_n;
        hist_q <= hist_shift[CRC_W-1:DATA_W];
        for (int i = NB - 2; i > 0; i--) base_hist_q[i] <= base_hist_q[i-1];
        base_hist_q[0] <= base;
      end else if (start_i) begin
        crc_q <= PRESET;
        cnt_q <= '0;
      end
    end
  end

  crc_x25_tx_emit #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (close && !check_i),
    .crc_i   (folded ^ XOR_OUT),
    .valid_o (tx_valid_o),
    .byte_o  (tx_byte_o)
  );

  assign crc_o   = crc_q ^ XOR_OUT;
  assign done_o  = done_q;
  assign match_o = match_q;
endmodule

// File: rtl/crc_x25_frame_engine_chk.sv
`timescale 1ns/1ps
module crc_x25_frame_engine_chk #(
  parameter int unsigned      CRC_W   = 16,
  parameter int unsigned      DATA_W  = 8,
  parameter logic [CRC_W-1:0] PRESET  = 16'hFFFF,
  parameter logic [CRC_W-1:0] XOR_OUT = 16'hFFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              start_i,
  input logic              last_i,
  input logic              check_i,
  input logic [DATA_W-1:0] data_i,
  input logic [CRC_W-1:0]  crc_o,
  input logic              done_o,
  input logic              match_o,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] tx_byte_o
);
  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i |=> done_o);

  // R6
  done_only_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && last_i) |=> !done_o);

  // R5
  idle_holds_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !start_i |=> $stable(crc_o));

  // R4
  bare_start_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_i |=> crc_o == (PRESET ^ XOR_OUT));

  // R10
  match_needs_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o && $past(check_i));

  // R9
  tx_low_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i && !check_i |=> tx_valid_o && tx_byte_o == crc_o[DATA_W-1:0]);

  // R9
  tx_high_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && last_i && !check_i, 2) && !$past(valid_i && last_i)
    |-> tx_valid_o && tx_byte_o == $past(crc_o[2*DATA_W-1:DATA_W]));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (!done_o && !match_o && !tx_valid_o);
    end
  end
endmodule

bind crc_x25_frame_engine crc_x25_frame_engine_chk #(
  .CRC_W(CRC_W), .DATA_W(DATA_W), .PRESET(PRESET), .XOR_OUT(XOR_OUT)
) u_chk (.*);

// File: tb/crc_x25_frame_engine_tb_top.sv
`timescale 1ns/1ps
module crc_x25_frame_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, start_i = 1'b0, last_i = 1'b0, check_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic [15:0] crc_o;
  logic        done_o, match_o, tx_valid_o;
  logic [7:0]  tx_byte_o;

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] fr [32];

  always #2.5 clk_i = ~clk_i;

  crc_x25_frame_engine dut_i (
    .clk_i, .rst_ni, .valid_i, .start_i, .last_i, .check_i, .data_i,
    .crc_o, .done_o, .match_o, .tx_valid_o, .tx_byte_o
  );

  localparam logic [71:0] VEC_BYTES [3] = '{72'h393837363534333231, 72'hFE, 72'h00};
  localparam int          VEC_LEN   [3] = '{9, 1, 1};
  localparam logic [15:0] VEC_EXP   [3] = '{16'h906E, 16'hEE89, 16'hF078};

  function automatic logic [15:0] model_fold(input logic [15:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic s, input logic l, input logic c);
    @(negedge clk_i);
    valid_i = 1'b1; start_i = s; last_i = l; check_i = c; data_i = d;
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0; start_i = 1'b0; last_i = 1'b0; check_i = 1'b0; data_i = 8'hA5;
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic run_frame(input int n, input logic c);
    for (int i = 0; i < n; i++) push(fr[i], i == 0, i == n - 1, c);
  endtask

  // builds a payload of n bytes plus a correct trailer in fr; returns total length
  function automatic int build_good(input int n, input int seed);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      fr[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
      r = model_fold(r, fr[i]);
    end
    r = ~r;
    fr[n]     = r[7:0];
    fr[n + 1] = r[15:8];
    return n + 2;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int len;
    logic [15:0] held;
    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 crc in reset", crc_o, 16'h0000);
    chk("R1 flags in reset", {done_o, match_o, tx_valid_o}, 3'b000);
    @(negedge clk_i); rst_ni = 1'b1;
    step();
    chk("R1 crc after reset", crc_o, 16'h0000);

    // R2 R3 vector table, generate mode; R6 R9 along the way
    for (int v = 0; v < 3; v++) begin
      for (int i = 0; i < VEC_LEN[v]; i++)
        push(VEC_BYTES[v][8*i +: 8], i == 0, i == VEC_LEN[v] - 1, 1'b0);
      chk(v == 0 ? "R3 check string" : "R2 single byte", crc_o, VEC_EXP[v]);
      chk("R6 done after last", done_o, 1'b1);
      chk("R9 tx low byte", {tx_valid_o, tx_byte_o}, {1'b1, VEC_EXP[v][7:0]});
      idle(); step();
      chk("R9 tx high byte", {tx_valid_o, tx_byte_o}, {1'b1, VEC_EXP[v][15:8]});
      chk("R6 done single cycle", done_o, 1'b0);
      step();
      chk("R9 tx ends", tx_valid_o, 1'b0);
    end

    // R4 back-to-back frames and mid-frame restart
    push(8'h00, 1'b1, 1'b1, 1'b0);
    chk("R4 first frame", crc_o, 16'hF078);
    push(8'hFE, 1'b1, 1'b1, 1'b0);
    chk("R4 second frame no idle", crc_o, 16'hEE89);
    chk("R6 done on consecutive closes", done_o, 1'b1);
    chk("R9 newer frame takes emission", {tx_valid_o, tx_byte_o}, {1'b1, 8'h89});
    push(8'h31, 1'b1, 1'b0, 1'b0);
    push(8'h00, 1'b1, 1'b1, 1'b0);
    chk("R4 start discards earlier bytes", crc_o, 16'hF078);
    idle(); step(); step();

    // R5 ignored cycles
    held = crc_o;
    @(negedge clk_i); last_i = 1'b1; check_i = 1'b1; data_i = 8'h3C;
    step();
    @(negedge clk_i); data_i = 8'hC3;
    step();
    chk("R5 crc held without valid", crc_o, held);
    chk("R5 no done without valid", done_o, 1'b0);

    // R4 bare start then continue without start
    @(negedge clk_i); start_i = 1'b1; last_i = 1'b0; check_i = 1'b0;
    step();
    chk("R4 bare start presets", crc_o, 16'h0000);
    push(8'hFE, 1'b0, 1'b1, 1'b0);
    chk("R4 byte after bare start", crc_o, 16'hEE89);
    idle(); step(); step();

    // R7 check mode
    for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
    fr[9] = 8'h6E; fr[10] = 8'h90;
    run_frame(11, 1'b1);
    chk("R7 check string trailer", {done_o, match_o}, 2'b11);
    chk("R9 no emission in check mode", tx_valid_o, 1'b0);
    fr[10] = 8'h91;
    run_frame(11, 1'b1);
    chk("R7 corrupt trailer high", {done_o, match_o}, 2'b10);
    len = build_good(18, 1);
    run_frame(len, 1'b1);
    chk("R7 model frame", match_o, 1'b1);
    fr[4] = fr[4] ^ 8'h10;
    run_frame(len, 1'b1);
    chk("R7 corrupt payload", match_o, 1'b0);
    len = build_good(5, 2);
    fr[len - 2] = fr[len - 2] ^ 8'h01;
    run_frame(len, 1'b1);
    chk("R7 corrupt trailer low", match_o, 1'b0);
    idle(); step();
    chk("R7 match single cycle", match_o, 1'b0);

    // R8 length boundary
    fr[0] = 8'h00; fr[1] = 8'h78; fr[2] = 8'hF0;
    run_frame(3, 1'b1);
    chk("R8 three-byte frame", match_o, 1'b1);
    fr[0] = 8'h00; fr[1] = 8'h00;
    run_frame(2, 1'b1);
    chk("R8 two-byte frame", {done_o, match_o}, 2'b10);
    run_frame(1, 1'b1);
    chk("R8 one-byte frame", {done_o, match_o}, 2'b10);

    // R10 good trailer in generate mode
    len = build_good(7, 3);
    run_frame(len, 1'b0);
    chk("R10 no match in generate mode", {done_o, match_o}, 2'b10);
    idle(); step(); step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule